// File: doc/BRIEF.md
# CAN Bit Timing Sampler

This block cuts each CAN bit time into time quanta and recovers one received bit per bit time. A bit time has three phases. A single synchronization quantum comes first. A programmable first segment follows it, and a programmable second segment ends the bit. The receive line is sampled at the sample point, which is the last quantum of the first segment. The received value comes either from that one sample or from a majority vote over three samples.

An 8-bit timing register holds the vote-mode bit and the two segment lengths. The register can always be read. A write changes it only while the controller reports initialization mode, which means the request flag and the acknowledge flag are both high. The quantum timing comes from an external one-cycle enable pulse. While the bus is idle, a falling edge on the receive line hard-synchronizes the bit counter. The block flags timing codes that break the minimum segment lengths.

The control is a state machine with three states. `ST_SYNC` is the synchronization quantum, `ST_SEG1` is the first segment and `ST_SEG2` is the second segment. It has these transitions:
- SYNC_TO_SEG1 happens on every quantum spent in `ST_SYNC`.
- SEG1_TO_SEG2 happens on the sample-point quantum.
- SEG2_TO_SYNC happens on the last quantum of segment 2.
- HARD_SYNC happens from any state into `ST_SEG1`, with the counter cleared, when a quantum sees the falling edge on an idle bus.

Top module: `can_bit_sampler`

## Requirements
- R1: The register layout is: bit 7 is the vote mode, bits 6:4 are the segment-2 code and bits 3:0 are the segment-1 code. `cfg_rdata` always shows the register, and the register resets to 0x00.
- R2: With vote mode 0, the received bit equals the line value in the sample-point quantum.
- R3: With vote mode 1, the received bit is the majority of the line values in the two quanta before the sample point and in the sample-point quantum.
- R4: Segment 1 lasts (segment-1 code + 1) quanta.
- R5: Segment 2 lasts (segment-2 code + 1) quanta.
- R6: A write changes the register only when `init_req` and `init_ack` are both 1 in the write cycle. Any other write leaves it unchanged.
- R7: `cfg_error` is 1 exactly when the segment-1 code is 0 or the segment-2 code is 0. The timing still runs with the lengths those codes give.
- R8: A bit time is one sync quantum, then segment 1, then segment 2. The sample point is the last quantum of segment 1.
- R9: A quantum in which `bus_idle` is 1, the previous quantum's line value was 1 and the current line value is 0 is taken as the sync quantum. The next quantum is the first quantum of segment 1.
- R10: `sample_valid` is high for exactly one clock, in the cycle after the sample-point quantum's enable, with the new `rx_bit`. `rx_bit` holds its value otherwise and resets to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tq_en | input | 1 | One-cycle pulse that marks one time quantum |
| rx_in | input | 1 | Receive line (1 recessive, 0 dominant) |
| bus_idle | input | 1 | High while the bus is idle, enables hard synchronization |
| init_req | input | 1 | Initialization request flag |
| init_ack | input | 1 | Initialization acknowledge flag |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_wdata | input | 8 | Timing register write data |
| cfg_rdata | output | 8 | Timing register contents |
| cfg_error | output | 1 | Invalid segment code present |
| sample_valid | output | 1 | One-cycle strobe for a new received bit |
| rx_bit | output | 1 | Received bit value |

## Verification
A pseudo-random receive line is applied under several register settings: a middle setting, the shortest valid setting, the longest setting and the invalid all-zero setting. Under each, a per-clock model confirms the strobe position and so separates the segment-length decoding from the order of the phases. Single and triple voting are compared on lines that glitch for one quantum. A glitch on the sample point alone gives a different result in the two modes, which shows the vote taps are in the right place. Falling edges on an idle bus, both at random and placed mid-bit, exercise hard synchronization. Writes with only one of the two initialization flags high must leave the register unchanged.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    typedef enum logic [1:0] {
        ST_SYNC = 2'd0,
        ST_SEG1 = 2'd1,
        ST_SEG2 = 2'd2
    } bt_state_e;

endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg #(
    parameter int S1W = 4,
    parameter int S2W = 3,
    localparam int CW = 1 + S1W + S2W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [CW-1:0]  wdata,
    input  logic           init_req,
    input  logic           init_ack,
    output logic [CW-1:0]  rdata,
    output logic           triple,
    output logic [S1W-1:0] seg1_code,
    output logic [S2W-1:0] seg2_code,
    output logic           cfg_error
);

    logic [CW-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we && init_req && init_ack) begin
            cfg_q <= wdata;
        end
    end

    always_comb begin
        rdata     = cfg_q;
        triple    = cfg_q[CW-1];
        seg2_code = cfg_q[S1W +: S2W];
        seg1_code = cfg_q[S1W-1:0];
        cfg_error = (seg1_code == '0) || (seg2_code == '0);
    end

    // R6
    lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !(init_req && init_ack)) |=> $stable(rdata));

endmodule

// File: rtl/can_bt_fsm.sv
module can_bt_fsm
    import can_bt_pkg::*;
#(
    parameter int S1W = 4,
    parameter int S2W = 3,
    localparam int CNTW = (S1W > S2W) ? S1W : S2W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tq_en,
    input  logic           rx_in,
    input  logic           bus_idle,
    input  logic [S1W-1:0] seg1_code,
    input  logic [S2W-1:0] seg2_code,
    output logic           sample_pt,
    output bt_state_e      state
);

    bt_state_e       st_q, st_n;
    logic [CNTW-1:0] cnt_q, cnt_n;
    logic            rx_prev;
    logic            hard_sync;
    logic [CNTW-1:0] seg1_last, seg2_last;

    assign seg1_last = CNTW'(seg1_code);
    assign seg2_last = CNTW'(seg2_code);
    assign hard_sync = tq_en && bus_idle && rx_prev && !rx_in;

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        if (hard_sync) begin
            st_n  = ST_SEG1;
            cnt_n = '0;
        end else if (tq_en) begin
            unique case (st_q)
                ST_SYNC: begin
                    st_n  = ST_SEG1;
                    cnt_n = '0;
                end
                ST_SEG1: begin
                    if (cnt_q >= seg1_last) begin
                        st_n  = ST_SEG2;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                ST_SEG2: begin
                    if (cnt_q >= seg2_last) begin
                        st_n  = ST_SYNC;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                default: begin
                    st_n  = ST_SYNC;
                    cnt_n = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_SYNC;
            cnt_q   <= '0;
            rx_prev <= 1'b1;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            if (tq_en) begin
                rx_prev <= rx_in;
            end
        end
    end

    always_comb begin
        state     = st_q;
        sample_pt = tq_en && !hard_sync && (st_q == ST_SEG1) && (cnt_q >= seg1_last);
    end

    // R8
    sync_one_tq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_en && st_q == ST_SYNC && !hard_sync) |=> (st_q == ST_SEG1 && cnt_q == '0));

    // R9
    hard_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tq_en && bus_idle && rx_prev && !rx_in) |=> (st_q == ST_SEG1 && cnt_q == '0));

endmodule

// File: rtl/can_bt_vote.sv
module can_bt_vote #(
    parameter int TAPS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tq_en,
    input  logic rx_in,
    input  logic triple,
    input  logic sample_pt,
    output logic sample_valid,
    output logic rx_bit
);

    logic [TAPS-1:0] hist;
    logic            maj;

    genvar g;
    generate
        for (g = 0; g < TAPS; g++) begin : g_tap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hist[g] <= 1'b1;
                end else if (tq_en) begin
                    if (g == 0) begin
                        hist[g] <= rx_in;
                    end else begin
                        hist[g] <= hist[g-1];
                    end
                end
            end
        end
    endgenerate

    assign maj = (hist[1] & hist[0]) | (hist[1] & rx_in) | (hist[0] & rx_in);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_valid <= 1'b0;
            rx_bit       <= 1'b1;
        end else begin
            sample_valid <= sample_pt;
            if (sample_pt) begin
                rx_bit <= triple ? maj : rx_in;
            end
        end
    end

    // R10
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R10
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_pt |=> $stable(rx_bit));

endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler
    import can_bt_pkg::*;
#(
    parameter int S1W = 4,
    parameter int S2W = 3,
    localparam int CW = 1 + S1W + S2W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tq_en,
    input  logic          rx_in,
    input  logic          bus_idle,
    input  logic          init_req,
    input  logic          init_ack,
    input  logic          cfg_we,
    input  logic [CW-1:0] cfg_wdata,
    output logic [CW-1:0] cfg_rdata,
    output logic          cfg_error,
    output logic          sample_valid,
    output logic          rx_bit
);

    logic           triple;
    logic [S1W-1:0] seg1_code;
    logic [S2W-1:0] seg2_code;
    logic           sample_pt;
    bt_state_e      state;

    can_bt_cfg #(.S1W(S1W), .S2W(S2W)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .init_req  (init_req),
        .init_ack  (init_ack),
        .rdata     (cfg_rdata),
        .triple    (triple),
        .seg1_code (seg1_code),
        .seg2_code (seg2_code),
        .cfg_error (cfg_error)
    );

    can_bt_fsm #(.S1W(S1W), .S2W(S2W)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tq_en     (tq_en),
        .rx_in     (rx_in),
        .bus_idle  (bus_idle),
        .seg1_code (seg1_code),
        .seg2_code (seg2_code),
        .sample_pt (sample_pt),
        .state     (state)
    );

    can_bt_vote #(.TAPS(2)) i_vote (
        .clk          (clk),
        .rst_n        (rst_n),
        .tq_en        (tq_en),
        .rx_in        (rx_in),
        .triple       (triple),
        .sample_pt    (sample_pt),
        .sample_valid (sample_valid),
        .rx_bit       (rx_bit)
    );

    // R8
    strobe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (state == ST_SEG2));

endmodule

// File: tb/test_can_bit_sampler.sv
module test_can_bit_sampler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tq_en = 1'b0;
    logic       rx_in = 1'b1;
    logic       bus_idle = 1'b0;
    logic       init_req = 1'b0;
    logic       init_ack = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       cfg_error;
    logic       sample_valid;
    logic       rx_bit;

    int tests = 0;
    int fails = 0;
    int strobes = 0;

    always #5 clk = ~clk;

    can_bit_sampler i_can_bit_sampler (
        .clk(clk), .rst_n(rst_n), .tq_en(tq_en), .rx_in(rx_in), .bus_idle(bus_idle),
        .init_req(init_req), .init_ack(init_ack), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_error(cfg_error), .sample_valid(sample_valid), .rx_bit(rx_bit)
    );

    // behavioural reference: phase 0 sync, 1 segment 1, 2 segment 2
    int         ph;
    int         idx;
    logic       rxp, h1, h0;
    logic       m_valid, m_bit;
    logic [7:0] m_cfg;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; idx = 0; rxp = 1; h1 = 1; h0 = 1;
            m_valid = 0; m_bit = 1; m_cfg = 8'h00;
        end else begin
            m_valid = 0;
            if (tq_en) begin
                if (bus_idle && rxp && !rx_in) begin
                    ph = 1; idx = 0;
                end else if (ph == 0) begin
                    ph = 1; idx = 0;
                end else if (ph == 1) begin
                    if (idx >= int'(m_cfg[3:0])) begin
                        m_valid = 1;
                        if (m_cfg[7]) m_bit = (int'(h1) + int'(h0) + int'(rx_in)) >= 2;
                        else          m_bit = rx_in;
                        ph = 2; idx = 0;
                    end else idx++;
                end else begin
                    if (idx >= int'(m_cfg[6:4])) begin ph = 0; idx = 0; end
                    else idx++;
                end
                h1 = h0; h0 = rx_in; rxp = rx_in;
            end
            if (cfg_we && init_req && init_ack) m_cfg = cfg_wdata;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 R6 register", cfg_rdata, m_cfg);
            chk("R7 error flag", {7'd0, cfg_error}, {7'd0, (m_cfg[3:0] == 0) || (m_cfg[6:4] == 0)});
            chk("R4 R5 R8 R9 R10 strobe", {7'd0, sample_valid}, {7'd0, m_valid});
            chk(m_cfg[7] ? "R3 triple bit" : "R2 single bit", {7'd0, rx_bit}, {7'd0, m_bit});
            if (sample_valid) strobes++;
        end
    end

    task automatic wr(input logic req, input logic ack, input logic [7:0] d);
        @(negedge clk);
        init_req = req; init_ack = ack; cfg_we = 1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0; init_req = 0; init_ack = 0;
    endtask

    task automatic quantum(input logic v, input int period);
        @(negedge clk);
        rx_in = v; tq_en = 1;
        @(negedge clk);
        tq_en = 0;
        for (int k = 1; k < period; k++) @(negedge clk);
    endtask

    task automatic run_rand(input int n, input int period, input int glitch_pct, input bit idle_rand);
        logic lvl;
        lvl = 1;
        for (int i = 0; i < n; i++) begin
            if ($urandom_range(0, 99) < 15) lvl = ~lvl;
            bus_idle = idle_rand ? ($urandom_range(0, 3) == 0) : 1'b0;
            quantum(($urandom_range(0, 99) < glitch_pct) ? ~lvl : lvl, period);
        end
        bus_idle = 0;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(7));
        repeat (3) @(negedge clk);
        // R1 R10: reset values
        chk("R1 reset register", cfg_rdata, 8'h00);
        chk("R10 reset strobe", {7'd0, sample_valid}, 8'h00);
        chk("R10 reset bit", {7'd0, rx_bit}, 8'h01);
        rst_n = 1;
        // R6: locked writes
        wr(1, 0, 8'h5A);
        wr(0, 1, 8'h5A);
        wr(0, 0, 8'h5A);
        chk("R6 locked write", cfg_rdata, 8'h00);
        // R2 R4 R5: single sample, seg1 5 Tq, seg2 3 Tq
        wr(1, 1, 8'h24);
        run_rand(300, 2, 10, 0);
        // R3: triple vote, same timing
        wr(1, 1, 8'hA4);
        run_rand(300, 2, 20, 0);
        // R3: sample-point-only glitch, resync by idle edge first
        bus_idle = 1;
        quantum(1, 2); quantum(0, 2);
        bus_idle = 0;
        for (int i = 0; i < 4; i++) quantum(1, 2);
        quantum(0, 2);
        quantum(1, 2);
        chk("R3 glitch outvoted", {7'd0, rx_bit}, 8'h01);
        // R2: same pattern in single mode gives dominant
        wr(1, 1, 8'h24);
        bus_idle = 1;
        quantum(1, 2); quantum(0, 2);
        bus_idle = 0;
        for (int i = 0; i < 4; i++) quantum(1, 2);
        quantum(0, 2);
        quantum(1, 2);
        chk("R2 single sample dominant", {7'd0, rx_bit}, 8'h00);
        // R4 R5: shortest valid, quanta back to back, triple
        wr(1, 1, 8'h91);
        run_rand(400, 1, 15, 0);
        // R4 R5: longest lengths
        wr(1, 1, 8'hFF);
        run_rand(400, 1, 10, 0);
        // R7: invalid all-zero codes still run
        wr(1, 1, 8'h00);
        chk("R7 invalid flagged", {7'd0, cfg_error}, 8'h01);
        run_rand(200, 1, 10, 0);
        // R9: hard sync with random idle periods
        wr(1, 1, 8'hB6);
        run_rand(600, 1, 10, 1);
        wr(1, 1, 8'h37);
        run_rand(600, 2, 10, 1);
        chk("R10 strobes observed", {7'd0, strobes > 100}, 8'h01);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule